// File: doc/BRIEF.md
# Hardwired Microoperation Control Generator

This block is the execute-phase controller for a small accumulator machine. It holds a one-hot step ring of seven timing states. It combines that ring with a decode of the instruction opcode in plain AND/OR logic and drives the datapath's control pins at every step. No microcode store is involved. On each step the block names one bus driver and one bus receiver by their fixed 3-bit datapath addresses. It marks whether a write happens, picks one of four ALU operations, and can raise a counter-return pulse. That pulse sends the ring back to its first step at the next clock edge.

The instruction register feeds the opcode input and holds it steady for the whole execute phase. The controller does not handle instruction fetch. The memory, the registers and the bus are not part of this block. Each instruction ends at its own step, so short instructions do not wait through all seven states. An opcode with no sequence emits idle controls and lets the ring run through all seven steps and wrap. All pins are plain level signals. No data passes through the block, so it has no flow-control handshake.

Top module: `mop_ctrl_unit`

## Requirements
- R1: While the active-low reset is low (asynchronous), and in the first cycle after it rises, the step output is 7'b0000001 (first step).
- R2: With no counter-return pulse, the one-hot step output moves up one bit per clock, and the seventh step (bit 6) is followed by the first step (bit 0).
- R3: When cnt_rst is high in a cycle, the step output is the first step in the next cycle, and that step has no write (wr_en low).
- R4: Bus addresses are: memory 0, MAR 1, PC 2, MBR 3, AC 4, input register 5, output register 6, IR 7. wr_en marks a write. In a step with no transfer, src_sel, dst_sel and alu_op are all zero and wr_en is low.
- R5: ALU codes are 00 none, 01 add, 10 subtract, 11 clear. A nonzero code only appears together with wr_en high and dst_sel = 4 (AC).
- R6: Load (opcode 4'h1) runs four steps: IR→MAR, memory→MBR, MBR→AC with ALU 00, and then a pulse-only step.
- R7: Add (opcode 4'h3) has the same step sequence as Load, except that its third step uses ALU code 01.
- R8: Subtract (opcode 4'h4) has the same step sequence as Add, except that its third step uses ALU code 10.
- R9: Store (opcode 4'h2) runs four steps: IR→MAR, AC→MBR, MBR→memory (dst_sel 0 with wr_en high), and then a pulse-only step.
- R10: Jump (opcode 4'h9) runs two steps: IR→PC, and then a pulse-only step.
- R11: Clear (opcode 4'hA) runs two steps: src_sel 0, dst_sel 4, wr_en high with ALU code 11, and then a pulse-only step.
- R12: Any other opcode gives idle controls and no pulse on all seven steps, and the ring wraps to the first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode field of the instruction register |
| step | output | 7 | One-hot timing state, bit k = step k |
| src_sel | output | 3 | Datapath address of the bus driver |
| dst_sel | output | 3 | Datapath address of the bus receiver |
| wr_en | output | 1 | Write strobe for the receiver |
| alu_op | output | 2 | ALU operation code |
| cnt_rst | output | 1 | Counter-return pulse |

## Verification
The bench builds the block with its default parameters: seven timing steps, a 4-bit opcode and 3-bit bus addresses. With these values an unrecognised opcode shows the complete ring wrap within seven clocks. Instructions run back to back, and the opcode changes on the first step after each pulse, so each early return is seen together with the step that follows it. A reset applied in the middle of an Add shows the ring forced back to its first step while the opcode is unchanged.

// File: rtl/mop_pkg.sv
package mop_pkg;
  localparam int OPC_W  = 4;
  localparam int SEL_W  = 3;
  localparam int ALU_W  = 2;
  localparam int NSTEPS = 7;

  // fixed datapath addresses on the shared bus
  localparam logic [SEL_W-1:0] BUS_MEM  = 3'd0;
  localparam logic [SEL_W-1:0] BUS_MAR  = 3'd1;
  localparam logic [SEL_W-1:0] BUS_PC   = 3'd2;
  localparam logic [SEL_W-1:0] BUS_MBR  = 3'd3;
  localparam logic [SEL_W-1:0] BUS_AC   = 3'd4;
  localparam logic [SEL_W-1:0] BUS_INR  = 3'd5;
  localparam logic [SEL_W-1:0] BUS_OUTR = 3'd6;
  localparam logic [SEL_W-1:0] BUS_IR   = 3'd7;

  localparam logic [ALU_W-1:0] ALU_NONE = 2'b00;
  localparam logic [ALU_W-1:0] ALU_ADD  = 2'b01;
  localparam logic [ALU_W-1:0] ALU_SUB  = 2'b10;
  localparam logic [ALU_W-1:0] ALU_CLR  = 2'b11;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h3;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'h4;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'h9;
  localparam logic [OPC_W-1:0] OP_CLEAR = 4'hA;

  // one decoded line per instruction with a sequence
  typedef struct packed {
    logic ld;
    logic st;
    logic ad;
    logic sb;
    logic jp;
    logic cl;
  } instr_lines_t;

  typedef struct packed {
    logic [SEL_W-1:0] src;
    logic [SEL_W-1:0] dst;
    logic             wr;
    logic [ALU_W-1:0] alu;
    logic             cr;
  } uop_t;
endpackage

// File: rtl/mop_step_ring.sv
module mop_step_ring #(
  parameter int NSTEPS = mop_pkg::NSTEPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  output logic [NSTEPS-1:0] step
);
  logic [NSTEPS-1:0] ring_q;

  // each bit is a flop; bit 0 is loaded by wrap or by the return pulse
  for (genvar i = 0; i < NSTEPS; i++) begin : g_bit
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q[i] <= 1'b1;
        else        ring_q[i] <= clr | ring_q[NSTEPS-1];
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q[i] <= 1'b0;
        else        ring_q[i] <= ~clr & ring_q[i-1];
      end
    end
  end

  assign step = ring_q;
endmodule

// File: rtl/mop_opdecode.sv
module mop_opdecode #(
  parameter int OPC_W = mop_pkg::OPC_W
) (
  input  logic [OPC_W-1:0]     opcode,
  output mop_pkg::instr_lines_t lines
);
  import mop_pkg::*;

  always_comb begin
    lines    = '0;
    lines.ld = (opcode == OPC_W'(OP_LOAD));
    lines.st = (opcode == OPC_W'(OP_STORE));
    lines.ad = (opcode == OPC_W'(OP_ADD));
    lines.sb = (opcode == OPC_W'(OP_SUB));
    lines.jp = (opcode == OPC_W'(OP_JUMP));
    lines.cl = (opcode == OPC_W'(OP_CLEAR));
  end
endmodule

// File: rtl/mop_matrix.sv
module mop_matrix #(
  parameter int USED_STEPS = 4
) (
  input  mop_pkg::instr_lines_t  lines,
  input  logic [USED_STEPS-1:0]  step,
  output mop_pkg::uop_t          uop
);
  import mop_pkg::*;

  localparam int NXFER = 9;

  // transfer table: driver, receiver, ALU code for each product term
  localparam logic [SEL_W-1:0] XSRC [NXFER] = '{
    BUS_IR, BUS_MEM, BUS_MBR, BUS_MBR, BUS_MBR, BUS_AC, BUS_MBR, BUS_IR, BUS_MEM};
  localparam logic [SEL_W-1:0] XDST [NXFER] = '{
    BUS_MAR, BUS_MBR, BUS_AC, BUS_AC, BUS_AC, BUS_MBR, BUS_MEM, BUS_PC, BUS_AC};
  localparam logic [ALU_W-1:0] XALU [NXFER] = '{
    ALU_NONE, ALU_NONE, ALU_NONE, ALU_ADD, ALU_SUB, ALU_NONE, ALU_NONE, ALU_NONE, ALU_CLR};

  logic             mem_class;  // instructions that go through MAR
  logic             rd_class;   // instructions that read memory into MBR
  logic [NXFER-1:0] hit;

  assign mem_class = lines.ld | lines.st | lines.ad | lines.sb;
  assign rd_class  = lines.ld | lines.ad | lines.sb;

  // AND of instruction line and timing step per transfer
  assign hit[0] = mem_class & step[0];
  assign hit[1] = rd_class  & step[1];
  assign hit[2] = lines.ld  & step[2];
  assign hit[3] = lines.ad  & step[2];
  assign hit[4] = lines.sb  & step[2];
  assign hit[5] = lines.st  & step[1];
  assign hit[6] = lines.st  & step[2];
  assign hit[7] = lines.jp  & step[0];
  assign hit[8] = lines.cl  & step[0];

  // OR plane: at most one term is live per step
  always_comb begin
    uop = '0;
    for (int i = 0; i < NXFER; i++) begin
      if (hit[i]) begin
        uop.src = uop.src | XSRC[i];
        uop.dst = uop.dst | XDST[i];
        uop.alu = uop.alu | XALU[i];
        uop.wr  = 1'b1;
      end
    end
    uop.cr = (mem_class & step[3]) | ((lines.jp | lines.cl) & step[1]);
  end
endmodule

// File: rtl/mop_ctrl_unit.sv
module mop_ctrl_unit #(
  parameter int OPC_W  = mop_pkg::OPC_W,
  parameter int SEL_W  = mop_pkg::SEL_W,
  parameter int ALU_W  = mop_pkg::ALU_W,
  parameter int NSTEPS = mop_pkg::NSTEPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  output logic [NSTEPS-1:0] step,
  output logic [SEL_W-1:0]  src_sel,
  output logic [SEL_W-1:0]  dst_sel,
  output logic              wr_en,
  output logic [ALU_W-1:0]  alu_op,
  output logic              cnt_rst
);
  localparam int USED_STEPS = 4;  // longest sequence including its return step

  mop_pkg::instr_lines_t lines;
  mop_pkg::uop_t         uop;
  logic [NSTEPS-1:0]     ring;

  mop_step_ring #(.NSTEPS(NSTEPS)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (uop.cr),
    .step  (ring)
  );

  mop_opdecode #(.OPC_W(OPC_W)) u_dec (
    .opcode (opcode),
    .lines  (lines)
  );

  mop_matrix #(.USED_STEPS(USED_STEPS)) u_mat (
    .lines (lines),
    .step  (ring[USED_STEPS-1:0]),
    .uop   (uop)
  );

  assign step    = ring;
  assign src_sel = uop.src;
  assign dst_sel = uop.dst;
  assign wr_en   = uop.wr;
  assign alu_op  = uop.alu;
  assign cnt_rst = uop.cr;
endmodule

// File: rtl/mop_ctrl_unit_chk.sv
module mop_ctrl_unit_chk #(
  parameter int OPC_W  = mop_pkg::OPC_W,
  parameter int SEL_W  = mop_pkg::SEL_W,
  parameter int ALU_W  = mop_pkg::ALU_W,
  parameter int NSTEPS = mop_pkg::NSTEPS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OPC_W-1:0]  opcode,
  input logic [NSTEPS-1:0] step,
  input logic [SEL_W-1:0]  src_sel,
  input logic [SEL_W-1:0]  dst_sel,
  input logic              wr_en,
  input logic [ALU_W-1:0]  alu_op,
  input logic              cnt_rst
);
  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step) == 1);

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_rst && !step[NSTEPS-1]) |=> step == ($past(step) << 1));

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step[NSTEPS-1] && !cnt_rst) |=> step[0]);

  a_r3_return_first: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> step[0]);

  a_r3_return_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |-> !wr_en);

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (src_sel == '0 && dst_sel == '0 && alu_op == '0));

  a_r5_alu_to_ac: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op != '0) |-> (wr_en && dst_sel == mop_pkg::BUS_AC));

  a_r10_jump_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_W'(mop_pkg::OP_JUMP) && step[0])
      |-> (src_sel == mop_pkg::BUS_IR && dst_sel == mop_pkg::BUS_PC && wr_en));
endmodule

bind mop_ctrl_unit mop_ctrl_unit_chk #(
  .OPC_W(OPC_W), .SEL_W(SEL_W), .ALU_W(ALU_W), .NSTEPS(NSTEPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .step(step),
  .src_sel(src_sel), .dst_sel(dst_sel), .wr_en(wr_en),
  .alu_op(alu_op), .cnt_rst(cnt_rst)
);

// File: tb/mop_ctrl_unit_test.sv
`timescale 1ns/1ps
module mop_ctrl_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opcode = 4'hF;
  logic [6:0] step;
  logic [2:0] src_sel, dst_sel;
  logic       wr_en;
  logic [1:0] alu_op;
  logic       cnt_rst;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  mop_ctrl_unit uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .step(step),
    .src_sel(src_sel), .dst_sel(dst_sel), .wr_en(wr_en),
    .alu_op(alu_op), .cnt_rst(cnt_rst)
  );

  // compare the full control word of step k, then advance one clock
  task automatic expect_step(input string tag, input int k, input logic [2:0] s,
                             input logic [2:0] d, input logic w, input logic [1:0] a,
                             input logic c);
    logic [16:0] act, exp;
    #1;
    act = {step, src_sel, dst_sel, wr_en, alu_op, cnt_rst};
    exp = {7'(1 << k), s, d, w, a, c};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s step%0d actual=%h expected=%h", tag, k, act, exp);
    end
    @(negedge clk);
  endtask

  task automatic expect_first(input string tag);
    #1;
    checks++;
    if (step !== 7'b0000001) begin
      errors++;
      $display("FAIL %s actual step=%b expected=%b", tag, step, 7'b0000001);
    end
  endtask

  task automatic t_reset;
    expect_first("R1");
  endtask

  task automatic t_load;
    opcode = 4'h1;
    expect_step("R6", 0, 3'd7, 3'd1, 1'b1, 2'b00, 1'b0);
    expect_step("R6", 1, 3'd0, 3'd3, 1'b1, 2'b00, 1'b0);
    expect_step("R6", 2, 3'd3, 3'd4, 1'b1, 2'b00, 1'b0);
    expect_step("R3", 3, 3'd0, 3'd0, 1'b0, 2'b00, 1'b1);
    expect_first("R3");
  endtask

  task automatic t_add;
    opcode = 4'h3;
    expect_step("R7", 0, 3'd7, 3'd1, 1'b1, 2'b00, 1'b0);
    expect_step("R7", 1, 3'd0, 3'd3, 1'b1, 2'b00, 1'b0);
    expect_step("R7", 2, 3'd3, 3'd4, 1'b1, 2'b01, 1'b0);
    expect_step("R7", 3, 3'd0, 3'd0, 1'b0, 2'b00, 1'b1);
    expect_first("R3");
  endtask

  task automatic t_sub;
    opcode = 4'h4;
    expect_step("R8", 0, 3'd7, 3'd1, 1'b1, 2'b00, 1'b0);
    expect_step("R8", 1, 3'd0, 3'd3, 1'b1, 2'b00, 1'b0);
    expect_step("R8", 2, 3'd3, 3'd4, 1'b1, 2'b10, 1'b0);
    expect_step("R8", 3, 3'd0, 3'd0, 1'b0, 2'b00, 1'b1);
    expect_first("R3");
  endtask

  task automatic t_store;
    opcode = 4'h2;
    expect_step("R9", 0, 3'd7, 3'd1, 1'b1, 2'b00, 1'b0);
    expect_step("R9", 1, 3'd4, 3'd3, 1'b1, 2'b00, 1'b0);
    expect_step("R9", 2, 3'd3, 3'd0, 1'b1, 2'b00, 1'b0);
    expect_step("R9", 3, 3'd0, 3'd0, 1'b0, 2'b00, 1'b1);
    expect_first("R3");
  endtask

  task automatic t_jump;
    opcode = 4'h9;
    expect_step("R10", 0, 3'd7, 3'd2, 1'b1, 2'b00, 1'b0);
    expect_step("R10", 1, 3'd0, 3'd0, 1'b0, 2'b00, 1'b1);
    expect_first("R10");
  endtask

  task automatic t_clear;
    opcode = 4'hA;
    expect_step("R11", 0, 3'd0, 3'd4, 1'b1, 2'b11, 1'b0);
    expect_step("R11", 1, 3'd0, 3'd0, 1'b0, 2'b00, 1'b1);
    expect_first("R11");
  endtask

  // unrecognised opcode: idle word on every step, ring wraps (R2, R4, R12)
  task automatic t_other(input logic [3:0] op);
    opcode = op;
    for (int k = 0; k < 7; k++) expect_step("R12", k, 3'd0, 3'd0, 1'b0, 2'b00, 1'b0);
    expect_first("R2");
  endtask

  // reset in the middle of an Add returns the ring to step 0 (R1)
  task automatic t_mid_reset;
    opcode = 4'h3;
    expect_step("R7", 0, 3'd7, 3'd1, 1'b1, 2'b00, 1'b0);
    expect_step("R7", 1, 3'd0, 3'd3, 1'b1, 2'b00, 1'b0);
    rst_n = 1'b0;
    expect_step("R1", 0, 3'd7, 3'd1, 1'b1, 2'b00, 1'b0);
    rst_n = 1'b1;
    expect_step("R1", 0, 3'd7, 3'd1, 1'b1, 2'b00, 1'b0);
    expect_step("R1", 1, 3'd0, 3'd3, 1'b1, 2'b00, 1'b0);
    expect_step("R7", 2, 3'd3, 3'd4, 1'b1, 2'b01, 1'b0);
    expect_step("R3", 3, 3'd0, 3'd0, 1'b0, 2'b00, 1'b1);
    expect_first("R3");
  endtask

  initial begin
    #(8.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_first("R1");
    rst_n = 1'b1;
    t_reset();
    t_other(4'hF);
    t_load();
    t_add();
    t_jump();
    t_sub();
    t_store();
    t_clear();
    t_other(4'h0);
    t_add();
    t_mid_reset();
    t_other(4'h7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule